// File: doc/BRIEF.md
# Serial Configuration Memory Read Sequencer

This block is the read side of a sequential configuration memory that feeds a bitstream into an FPGA. A fixed image of `TERM_CNT+1` words is held in a parameter. When the device is selected and released from reset, an internal address walks that image one word per clock, starting at word 0. Each word is presented on a tri-state data output, given as a value plus an enable. When the last word has been sent, the address stops, the data output floats, and an active-low cascade output drops so that the next memory in a chain can take over.

A power-up hold timer keeps the internal reset output low for a parameterised number of cycles after the system reset is released. During that time no data is streamed. A digital low-supply input reruns that same power-up sequence. Driving the chip-enable input high, or pulling the active-low output-enable/reset input low, returns the address to 0. Chip enable high also raises the standby indicator.

Top module: `cfg_prom_seq`

## Requirements
- R1: After `rst_n` is released with `low_supply` low, `hold_rst_n` stays low for exactly `HOLD_CYC` rising edges and then stays high.
- R2: While `hold_rst_n` is low, `data_oe` is 0 and no word is streamed; the address stays at 0.
- R3: While `chip_en` is high, `standby` is 1, `data_oe` is 0, and `casc_ce_n` is 1. Once `chip_en` goes low again (with the device otherwise enabled), streaming restarts from word 0.
- R4: While `oe_rst_n` is low and `chip_en` is low, `data_oe` is 0 and `casc_ce_n` is 1. After `oe_rst_n` rises, streaming restarts from word 0.
- R5: In enabled operation (`chip_en` low, `oe_rst_n` high, `hold_rst_n` high), the k-th rising edge puts word k-1 on `data_o` with `data_oe` high. Words come one per clock, from word 0 up to word `TERM_CNT`. Word i is bits `[i*WORD_W +: WORD_W]` of `ROM_IMAGE`.
- R6: On the edge after word `TERM_CNT` is shown, `data_oe` goes to 0. It stays 0, and the address does not change, until reset, standby or `oe_rst_n` low.
- R7: `casc_ce_n` goes low on the same edge that `data_oe` drops after the terminal word. It stays low while the device remains enabled, and it is high in every other state. In one full stream it falls exactly once.
- R8: A `low_supply` high sampled on a rising edge has the same effect as `rst_n` low: the hold timer restarts, `hold_rst_n` goes low, and the address returns to 0.
- R9: `data_oe` and `casc_ce_n` follow `chip_en` and `oe_rst_n` combinationally, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low system reset (power-on) |
| low_supply | input | 1 | High when supply is below the brown-out level; acts as power-up reset |
| oe_rst_n | input | 1 | Active-low output-enable / address reset |
| chip_en | input | 1 | Active-high chip enable; high selects standby |
| data_o | output | WORD_W | Data word value |
| data_oe | output | 1 | Drive enable for `data_o` (0 means high impedance) |
| casc_ce_n | output | 1 | Active-low chip enable for the next device in the chain |
| standby | output | 1 | High while in low-power standby |
| hold_rst_n | output | 1 | Internal reset output, low during the power-up hold |

## Verification
The hardest state to reach from the ports is the one where the full image has been streamed and the device then sits past the terminal count. Reaching it needs `TERM_CNT+1` enabled cycles in a row after the hold timer expires. A short break in chip enable, output enable or supply level at any point restarts the walk from word 0. The stimulus therefore runs directed passes that stay enabled for the whole image. These are followed by random runs that interrupt enable only rarely, so that many passes reach the terminal word. Some of those interruptions fall in the same cycle as the terminal word or just after it.

// File: rtl/cfg_prom_pkg.sv
// Package: shared types for the configuration memory read sequencer.
// Assumes nothing beyond IEEE 1800-2017 types.
package cfg_prom_pkg;

    // Walk phase of the address sequencer.
    typedef enum logic {
        PH_WALK = 1'b0,   // address below or at the terminal count, streaming
        PH_PAST = 1'b1    // terminal count passed, address frozen
    } walk_phase_t;

endpackage

// File: rtl/cps_hold_timer.sv
// Module: cps_hold_timer
// Counts HOLD_CYC enabled clocks after a synchronous power-up reset and then
// raises hold_done. A low supply indication restarts the count.
// Assumes HOLD_CYC >= 1.
module cps_hold_timer #(
    parameter int HOLD_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_supply,
    output logic hold_done
);

    localparam int CNT_W = $clog2(HOLD_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // Power-up hold counter; saturates once the hold time has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n || low_supply) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(HOLD_CYC - 1)) begin
                done_q <= 1'b1;
            end
        end
    end

    assign hold_done = done_q;

    // R1: the release only follows a full count.
    assert_hold_full_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(cnt_q) == CNT_W'(HOLD_CYC - 1)));

    // R8: a low supply always drops the release on the following edge.
    assert_low_supply_rehold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        low_supply |=> !done_q);

endmodule

// File: rtl/cps_addr_seq.sv
// Module: cps_addr_seq
// Address walker: resets to 0 under standby, output-enable low or hold, and
// otherwise steps one word per clock up to TERM_CNT, then freezes.
// Assumes TERM_CNT < 2**ADDR_W.
module cps_addr_seq
    import cfg_prom_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int TERM_CNT = 11
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              hold_done,
    input  logic              chip_en,
    input  logic              oe_rst_n,
    output logic [ADDR_W-1:0] addr,
    output logic              fetch,
    output logic              word_vld,
    output walk_phase_t       phase
);

    localparam logic [ADDR_W-1:0] TC = ADDR_W'(TERM_CNT);

    logic [ADDR_W-1:0] addr_q;
    walk_phase_t       phase_q;
    logic              vld_q;
    logic              held;

    // Any of these conditions pins the address at 0.
    assign held  = !hold_done || chip_en || !oe_rst_n;
    assign fetch = !held && (phase_q == PH_WALK);

    // Address, phase and word-valid state.
    always_ff @(posedge clk) begin
        if (!sys_rst_n || held) begin
            addr_q  <= '0;
            phase_q <= PH_WALK;
            vld_q   <= 1'b0;
        end else if (phase_q == PH_WALK) begin
            vld_q <= 1'b1;
            if (addr_q == TC) begin
                phase_q <= PH_PAST;
            end else begin
                addr_q <= addr_q + 1'b1;
            end
        end else begin
            vld_q <= 1'b0;
        end
    end

    assign addr     = addr_q;
    assign word_vld = vld_q;
    assign phase    = phase_q;

    // R3 and R4: standby or output-enable low return the address to 0.
    assert_addr_cleared_R3: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (chip_en || !oe_rst_n) |=> (addr_q == '0 && phase_q == PH_WALK));

    // R6: past the terminal count, an enabled device keeps its address.
    assert_addr_frozen_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (phase_q == PH_PAST && !held) |=> (phase_q == PH_PAST && $stable(addr_q)));

    // R5: the address never runs beyond the terminal count.
    assert_addr_bound_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        addr_q <= TC);

    // R2: no word becomes valid while the hold is active.
    assert_no_word_in_hold_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !hold_done |=> !vld_q);

endmodule

// File: rtl/cps_rom_read.sv
// Module: cps_rom_read
// Parameter-held image and registered read port: on a fetch strobe the word
// at the given address is captured.
// Assumes ROM_IMAGE holds TERM_CNT+1 words, word i in bits [i*WORD_W +: WORD_W].
module cps_rom_read #(
    parameter int WORD_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int TERM_CNT = 11,
    parameter logic [(TERM_CNT+1)*WORD_W-1:0] ROM_IMAGE = '0
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              fetch,
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] data
);

    localparam int DEPTH = TERM_CNT + 1;

    logic [WORD_W-1:0] rom_w [DEPTH];
    logic [WORD_W-1:0] data_q;

    // Unpack the parameter image into one word per address.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
        assign rom_w[gi] = ROM_IMAGE[gi*WORD_W +: WORD_W];
    end

    // Output data register, loaded from the current address on fetch.
    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            data_q <= '0;
        end else if (fetch) begin
            data_q <= rom_w[addr];
        end
    end

    assign data = data_q;

    // R5: a fetch only reads within the image.
    assert_fetch_in_image_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        fetch |-> (int'(addr) < DEPTH));

endmodule

// File: rtl/cfg_prom_seq.sv
// Module: cfg_prom_seq (top)
// Read-side sequencer of a serial configuration memory: power-up hold,
// address walk with saturation at the terminal count, tri-state data output
// enable, cascade enable for a following device and standby indicator.
// Assumes synchronous control inputs and HOLD_CYC >= 1.
module cfg_prom_seq
    import cfg_prom_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int TERM_CNT = 11,
    parameter int HOLD_CYC = 250,
    parameter logic [(TERM_CNT+1)*WORD_W-1:0] ROM_IMAGE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              low_supply,
    input  logic              oe_rst_n,
    input  logic              chip_en,
    output logic [WORD_W-1:0] data_o,
    output logic              data_oe,
    output logic              casc_ce_n,
    output logic              standby,
    output logic              hold_rst_n
);

    logic              hold_done;
    logic              sys_rst_n;
    logic [ADDR_W-1:0] addr;
    logic              fetch;
    logic              word_vld;
    walk_phase_t       phase;
    logic              enabled;

    assign sys_rst_n = rst_n && !low_supply;

    cps_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .low_supply (low_supply),
        .hold_done  (hold_done)
    );

    cps_addr_seq #(.ADDR_W(ADDR_W), .TERM_CNT(TERM_CNT)) u_seq (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .hold_done (hold_done),
        .chip_en   (chip_en),
        .oe_rst_n  (oe_rst_n),
        .addr      (addr),
        .fetch     (fetch),
        .word_vld  (word_vld),
        .phase     (phase)
    );

    cps_rom_read #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .TERM_CNT(TERM_CNT), .ROM_IMAGE(ROM_IMAGE)
    ) u_rom (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .fetch     (fetch),
        .addr      (addr),
        .data      (data_o)
    );

    // Output control: combinational from registered state and live controls.
    assign enabled    = hold_done && !chip_en && oe_rst_n;
    assign data_oe    = enabled && word_vld;
    assign casc_ce_n  = !(enabled && phase == PH_PAST && !word_vld);
    assign standby    = chip_en;
    assign hold_rst_n = hold_done;

    // R7: the cascade enable and the data drive are never active together.
    assert_casc_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !casc_ce_n |-> !data_oe);

    // R3: standby always floats the data and releases the cascade.
    assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chip_en |-> (!data_oe && casc_ce_n && standby));

    // R2: no drive while the hold output is low.
    assert_hold_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_rst_n |-> (!data_oe && casc_ce_n));

endmodule

// File: tb/sim_cfg_prom_seq.sv
module sim_cfg_prom_seq;

    localparam int WORD_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int TERM_CNT = 11;
    localparam int HOLD_CYC = 20;
    localparam int DEPTH    = TERM_CNT + 1;

    function automatic logic [WORD_W-1:0] img_word(input int i);
        return WORD_W'((i * 29 + 7) ^ 8'h5A);
    endfunction

    function automatic logic [DEPTH*WORD_W-1:0] build_img();
        logic [DEPTH*WORD_W-1:0] v;
        v = '0;
        for (int i = 0; i < DEPTH; i++) v[i*WORD_W +: WORD_W] = img_word(i);
        return v;
    endfunction

    localparam logic [DEPTH*WORD_W-1:0] IMG = build_img();

    logic clk = 1'b0;
    logic rst_n = 1'b0, low_supply = 1'b0, oe_rst_n = 1'b1, chip_en = 1'b0;
    logic [WORD_W-1:0] data_o;
    logic data_oe, casc_ce_n, standby, hold_rst_n;

    int n_chk = 0, n_bad = 0;

    // reference model state
    int  m_hcnt = 0;
    bit  m_hdone = 0, m_past = 0, m_vld = 0;
    int  m_addr = 0;
    logic [WORD_W-1:0] m_data = '0;

    always #2 clk = ~clk;

    cfg_prom_seq #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .TERM_CNT(TERM_CNT),
        .HOLD_CYC(HOLD_CYC), .ROM_IMAGE(IMG)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .low_supply(low_supply), .oe_rst_n(oe_rst_n),
        .chip_en(chip_en), .data_o(data_o), .data_oe(data_oe),
        .casc_ce_n(casc_ce_n), .standby(standby), .hold_rst_n(hold_rst_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // model update at a rising edge, using the inputs present at that edge
    task automatic model_edge();
        if (!rst_n || low_supply) begin
            m_hcnt = 0; m_hdone = 0; m_addr = 0; m_past = 0; m_vld = 0; m_data = '0;
        end else if (!m_hdone || chip_en || !oe_rst_n) begin
            if (!m_hdone) begin
                m_hcnt++;
                if (m_hcnt == HOLD_CYC) m_hdone = 1;
            end
            m_addr = 0; m_past = 0; m_vld = 0;
        end else if (!m_past) begin
            m_data = img_word(m_addr); m_vld = 1;
            if (m_addr == TERM_CNT) m_past = 1; else m_addr++;
        end else begin
            m_vld = 0;
        end
    endtask

    task automatic step();
        model_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic compare_all(input string tag);
        bit en;
        en = m_hdone && !chip_en && oe_rst_n;
        chk({tag, " hold R1"}, hold_rst_n, m_hdone);
        chk({tag, " oe R5"}, data_oe, en && m_vld);
        chk({tag, " casc R7"}, casc_ce_n, !(en && m_past && !m_vld));
        chk({tag, " standby R3"}, standby, chip_en);
        if (en && m_vld) chk({tag, " data R5"}, data_o, m_data);
    endtask

    // stream a full image from an enabled start; checks every word and the drop
    task automatic full_stream(input string tag);
        int falls;
        bit prev;
        falls = 0;
        prev = casc_ce_n;
        for (int i = 0; i < DEPTH; i++) begin
            step();
            chk({tag, " word oe R5"}, data_oe, 1'b1);
            chk({tag, " word data R5"}, data_o, img_word(i));
            if (prev && !casc_ce_n) falls++;
            prev = casc_ce_n;
        end
        for (int i = 0; i < 5; i++) begin
            step();
            chk({tag, " past oe R6"}, data_oe, 1'b0);
            chk({tag, " past casc R7"}, casc_ce_n, 1'b0);
            if (prev && !casc_ce_n) falls++;
            prev = casc_ce_n;
        end
        chk({tag, " single cascade fall R7"}, falls, 1);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int hold_len;
        void'($urandom(32'h1234_5678));
        // reset state
        rst_n = 0;
        repeat (3) step();
        chk("reset hold R1", hold_rst_n, 1'b0);
        chk("reset oe R2", data_oe, 1'b0);
        chk("reset casc R7", casc_ce_n, 1'b1);

        // R1: hold length
        rst_n = 1;
        hold_len = 0;
        while (!hold_rst_n && hold_len < 1000) begin
            chk("hold oe R2", data_oe, 1'b0);
            step();
            hold_len++;
        end
        chk("hold length R1", hold_len, HOLD_CYC);

        // R5/R6/R7 full stream
        full_stream("first");

        // R3: standby returns address to 0
        chip_en = 1;
        #0.5;
        chk("standby comb oe R9", data_oe, 1'b0);
        chk("standby comb casc R9", casc_ce_n, 1'b1);
        chk("standby flag R3", standby, 1'b1);
        step(); step();
        chk("standby casc R3", casc_ce_n, 1'b1);
        chip_en = 0;
        full_stream("after standby R3");

        // R4: output-enable low mid-stream restarts at word 0
        oe_rst_n = 0;
        step();
        chk("oe low data R4", data_oe, 1'b0);
        oe_rst_n = 1;
        step(); step(); step();
        oe_rst_n = 0;
        #0.5;
        chk("oe low comb R9", data_oe, 1'b0);
        step();
        chk("oe low casc R4", casc_ce_n, 1'b1);
        oe_rst_n = 1;
        full_stream("after oe R4");

        // R8: low supply reruns the hold
        low_supply = 1;
        step();
        chk("low supply hold R8", hold_rst_n, 1'b0);
        low_supply = 0;
        hold_len = 0;
        while (!hold_rst_n && hold_len < 1000) begin step(); hold_len++; end
        chk("rehold length R8", hold_len, HOLD_CYC);
        full_stream("after low supply R8");

        // random mix checked against the model
        for (int c = 0; c < 20000; c++) begin
            if ($urandom_range(0, 39) == 0) chip_en = ~chip_en;
            if ($urandom_range(0, 59) == 0) oe_rst_n = ~oe_rst_n;
            low_supply = ($urandom_range(0, 699) == 0);
            rst_n = ($urandom_range(0, 1999) != 0);
            #0.5;
            compare_all("rand comb");
            step();
            compare_all("rand");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule